// File: doc/BRIEF.md
# I2C Byte Role and Address Recognition Controller

This block follows an I2C interface at the byte level once a start condition has been seen. It decides whether the first byte of a transfer is a slave address with a direction bit, or whether all bytes are plain payload. In address mode the first byte is compared with a programmed 7-bit own address, and a match raises an addressed-as-slave flag. In free-data mode nothing is matched, and every byte is handed on as data.

The block also keeps two role flags, master and transmitter. Software sets them with write strobes. Hardware changes them on bus events: a stop condition or lost arbitration drops the master role. When the block is a slave in address mode, the direction bit of the first byte loads the transmitter flag.

Bit shifting, clock generation and acknowledge driving sit in neighbouring logic. That logic supplies this block with start, stop and arbitration-lost strobes and with each completed byte.

Top module: `i2c_role_ctrl`

## Requirements
- R1: The synchronous active-high reset clears role_master, role_xmit, slave_hit and data_strobe to 0 on the next clock edge.
- R2: In address mode (cfg_free_data=0), a byte completed while the device is a slave and the byte is the first one since a start raises slave_hit one cycle after rx_done, provided rx_byte[7:1] equals cfg_own_addr. A mismatching byte, or a byte received while role_master=1, leaves slave_hit at 0.
- R3: bus_start or bus_stop clears slave_hit one cycle later, and either one overrides a match in the same cycle.
- R4: In address mode the first byte after a start gives no data_strobe. Each later byte pulses data_strobe for one cycle, one cycle after rx_done. A byte that arrives after a stop, with no start since, counts as a later byte.
- R5: In free-data mode (cfg_free_data=1) every completed byte pulses data_strobe, including the first one after a start. slave_hit stays 0 and role_xmit does not follow the direction bit.
- R6: A software master write (sw_mst_we=1) loads sw_mst_val into role_master one cycle later.
- R7: bus_stop or arb_lost clears role_master one cycle later and wins over a software master write in the same cycle.
- R8: A software transmit write (sw_trx_we=1) loads sw_trx_val into role_xmit one cycle later.
- R9: When the device is a slave in address mode, the first byte after a start loads rx_byte[0] into role_xmit one cycle after rx_done, and this wins over a software transmit write in the same cycle. Later bytes, and first bytes received while role_master=1, leave role_xmit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_free_data | input | 1 | 1 = free-data mode, 0 = address mode |
| cfg_own_addr | input | 7 | Own slave address, compared with rx_byte[7:1] |
| sw_mst_we | input | 1 | Software write strobe for the master flag |
| sw_mst_val | input | 1 | Value written to the master flag |
| sw_trx_we | input | 1 | Software write strobe for the transmit flag |
| sw_trx_val | input | 1 | Value written to the transmit flag |
| bus_start | input | 1 | Start condition strobe |
| bus_stop | input | 1 | Stop condition strobe |
| arb_lost | input | 1 | Arbitration lost strobe |
| rx_byte | input | 8 | Completed byte, bit 0 is the direction bit |
| rx_done | input | 1 | Byte-complete strobe |
| role_master | output | 1 | 1 = master, 0 = slave |
| role_xmit | output | 1 | 1 = transmitter, 0 = receiver |
| slave_hit | output | 1 | Device was addressed as slave in this transfer |
| data_strobe | output | 1 | One-cycle pulse per data byte |

## Verification
The hardest cases to reach are collisions inside a single cycle. One is a software write landing in the same cycle as a hardware update, such as a transmit write on the address byte or a master write together with a stop or lost arbitration. The other is a byte arriving after a stop with no start in between. The vector table drives these combinations on purpose, one cycle each, and checks all four outputs after every edge. It also flips between free-data and address mode between transfers so that the first-byte tracking is exercised in both.

// File: rtl/i2c_role_pkg.sv
package i2c_role_pkg;
    typedef struct packed {
        logic first;
        logic strobe;
    } phase_st_t;

    typedef struct packed {
        logic master;
        logic xmit;
    } role_st_t;
endpackage

// File: rtl/i2c_frame_phase.sv
module i2c_frame_phase
    import i2c_role_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic free_mode,
    input  logic bus_start,
    input  logic bus_stop,
    input  logic rx_done,
    output logic first_q,
    output logic data_strobe_q
);
    phase_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = rx_done && (free_mode || !st_q.first);
        if (rx_done)
            st_d.first = 1'b0;
        if (bus_stop)
            st_d.first = 1'b0;
        if (bus_start)
            st_d.first = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign first_q       = st_q.first;
    assign data_strobe_q = st_q.strobe;

    assert_free_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_done && free_mode) |=> data_strobe_q);
    assert_addr_byte_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_done && first_q && !free_mode) |=> !data_strobe_q);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
    parameter int ADDR_W = 7,
    localparam int BYTE_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              free_mode,
    input  logic              is_master,
    input  logic              first_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_done,
    input  logic              bus_start,
    input  logic              bus_stop,
    output logic              slave_hit_q
);
    logic [ADDR_W-1:0] bit_eq;
    logic              addr_eq;
    logic              hit_d;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_cmp
        assign bit_eq[i] = rx_byte[i+1] ~^ own_addr[i];
    end
    assign addr_eq = &bit_eq;

    always_comb begin
        hit_d = slave_hit_q;
        if (rx_done && first_byte && !free_mode && !is_master && addr_eq)
            hit_d = 1'b1;
        if (bus_start || bus_stop)
            hit_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) slave_hit_q <= 1'b0;
        else     slave_hit_q <= hit_d;
    end

    assert_hit_on_match_R2: assert property (@(posedge clk) disable iff (rst)
        (rx_done && first_byte && !free_mode && !is_master &&
         (rx_byte[BYTE_W-1:1] == own_addr) && !bus_start && !bus_stop) |=> slave_hit_q);
    assert_hit_cleared_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_start || bus_stop) |=> !slave_hit_q);
    assert_no_hit_free_R5: assert property (@(posedge clk) disable iff (rst)
        (free_mode && !slave_hit_q) |=> !slave_hit_q);
endmodule

// File: rtl/i2c_role_regs.sv
module i2c_role_regs
    import i2c_role_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic free_mode,
    input  logic first_byte,
    input  logic dir_bit,
    input  logic rx_done,
    input  logic sw_mst_we,
    input  logic sw_mst_val,
    input  logic sw_trx_we,
    input  logic sw_trx_val,
    input  logic bus_stop,
    input  logic arb_lost,
    output logic master_q,
    output logic xmit_q
);
    role_st_t st_d, st_q;
    logic     dir_load;

    assign dir_load = rx_done && first_byte && !free_mode && !st_q.master;

    always_comb begin
        st_d = st_q;
        if (sw_mst_we)
            st_d.master = sw_mst_val;
        if (bus_stop || arb_lost)
            st_d.master = 1'b0;
        if (sw_trx_we)
            st_d.xmit = sw_trx_val;
        if (dir_load)
            st_d.xmit = dir_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign master_q = st_q.master;
    assign xmit_q   = st_q.xmit;

    assert_master_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_stop || arb_lost) |=> !master_q);
    assert_master_write_R6: assert property (@(posedge clk) disable iff (rst)
        (sw_mst_we && !bus_stop && !arb_lost) |=> (master_q == $past(sw_mst_val)));
    assert_dir_load_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_done && first_byte && !free_mode && !master_q) |=> (xmit_q == $past(dir_bit)));
    assert_xmit_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!sw_trx_we && !(rx_done && first_byte)) |=> $stable(xmit_q));
endmodule

// File: rtl/i2c_role_ctrl.sv
module i2c_role_ctrl #(
    parameter int ADDR_W = 7,
    localparam int BYTE_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_free_data,
    input  logic [ADDR_W-1:0] cfg_own_addr,
    input  logic              sw_mst_we,
    input  logic              sw_mst_val,
    input  logic              sw_trx_we,
    input  logic              sw_trx_val,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              arb_lost,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_done,
    output logic              role_master,
    output logic              role_xmit,
    output logic              slave_hit,
    output logic              data_strobe
);
    logic first_q;

    i2c_frame_phase u_phase (
        .clk          (clk),
        .rst          (rst),
        .free_mode    (cfg_free_data),
        .bus_start    (bus_start),
        .bus_stop     (bus_stop),
        .rx_done      (rx_done),
        .first_q      (first_q),
        .data_strobe_q(data_strobe)
    );

    i2c_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .clk        (clk),
        .rst        (rst),
        .free_mode  (cfg_free_data),
        .is_master  (role_master),
        .first_byte (first_q),
        .own_addr   (cfg_own_addr),
        .rx_byte    (rx_byte),
        .rx_done    (rx_done),
        .bus_start  (bus_start),
        .bus_stop   (bus_stop),
        .slave_hit_q(slave_hit)
    );

    i2c_role_regs u_roles (
        .clk       (clk),
        .rst       (rst),
        .free_mode (cfg_free_data),
        .first_byte(first_q),
        .dir_bit   (rx_byte[0]),
        .rx_done   (rx_done),
        .sw_mst_we (sw_mst_we),
        .sw_mst_val(sw_mst_val),
        .sw_trx_we (sw_trx_we),
        .sw_trx_val(sw_trx_val),
        .bus_stop  (bus_stop),
        .arb_lost  (arb_lost),
        .master_q  (role_master),
        .xmit_q    (role_xmit)
    );

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!role_master && !role_xmit && !slave_hit && !data_strobe));
endmodule

// File: tb/i2c_role_ctrl_tb.sv
module i2c_role_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_free_data = 1'b0;
    logic [6:0] cfg_own_addr = 7'h5A;
    logic       sw_mst_we = 1'b0, sw_mst_val = 1'b0;
    logic       sw_trx_we = 1'b0, sw_trx_val = 1'b0;
    logic       bus_start = 1'b0, bus_stop = 1'b0, arb_lost = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_done = 1'b0;
    logic       role_master, role_xmit, slave_hit, data_strobe;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    i2c_role_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_free_data(cfg_free_data), .cfg_own_addr(cfg_own_addr),
        .sw_mst_we(sw_mst_we), .sw_mst_val(sw_mst_val),
        .sw_trx_we(sw_trx_we), .sw_trx_val(sw_trx_val),
        .bus_start(bus_start), .bus_stop(bus_stop), .arb_lost(arb_lost),
        .rx_byte(rx_byte), .rx_done(rx_done),
        .role_master(role_master), .role_xmit(role_xmit),
        .slave_hit(slave_hit), .data_strobe(data_strobe)
    );

    // vector: {free,start,stop,arb,mwe,mval,twe,tval,done} byte {m,t,h,s}
    localparam int NV = 25;
    localparam logic [20:0] VEC [NV] = '{
        {9'b0_100_0000_0, 8'h00, 4'b0000}, // 0  start                         R4
        {9'b0_000_0000_1, 8'hB5, 4'b0110}, // 1  match, dir 1                  R2 R9
        {9'b0_000_0000_1, 8'h33, 4'b0111}, // 2  second byte strobes           R4
        {9'b0_000_0000_0, 8'h00, 4'b0110}, // 3  idle                          R4
        {9'b0_010_0000_0, 8'h00, 4'b0100}, // 4  stop clears hit               R3
        {9'b0_100_0000_0, 8'h00, 4'b0100}, // 5  start                         R3
        {9'b0_000_0000_1, 8'hB4, 4'b0010}, // 6  match, dir 0                  R9
        {9'b0_100_0000_0, 8'h00, 4'b0000}, // 7  start clears hit              R3
        {9'b0_000_0000_1, 8'h12, 4'b0000}, // 8  mismatch                      R2
        {9'b0_000_1100_0, 8'h00, 4'b1000}, // 9  sw master 1                   R6
        {9'b0_100_0000_0, 8'h00, 4'b1000}, // 10 start                         R6
        {9'b0_000_0000_1, 8'hB5, 4'b1000}, // 11 master: no hit, no dir        R9
        {9'b0_000_0011_0, 8'h00, 4'b1100}, // 12 sw trx 1                      R8
        {9'b0_001_1100_0, 8'h00, 4'b0100}, // 13 arb lost beats write          R7
        {9'b0_000_1100_0, 8'h00, 4'b1100}, // 14 sw master 1                   R6
        {9'b0_010_0000_0, 8'h00, 4'b0100}, // 15 stop drops master             R7
        {9'b0_000_0000_1, 8'h44, 4'b0101}, // 16 byte after stop is data       R4
        {9'b0_000_0010_0, 8'h00, 4'b0000}, // 17 sw trx 0                      R8
        {9'b1_100_0000_0, 8'h00, 4'b0000}, // 18 free mode start               R5
        {9'b1_000_0000_1, 8'hB5, 4'b0001}, // 19 free first byte strobes       R5
        {9'b1_000_0000_1, 8'h00, 4'b0001}, // 20 free later byte               R5
        {9'b0_100_0000_0, 8'h00, 4'b0000}, // 21 address mode start            R2
        {9'b0_000_0010_1, 8'hB5, 4'b0110}, // 22 dir beats sw trx 0            R9
        {9'b0_000_0000_1, 8'h20, 4'b0111}, // 23 later byte keeps trx          R9
        {9'b0_010_1100_0, 8'h00, 4'b0100}  // 24 stop beats master write       R7
    };
    string TAG [NV] = '{"R4","R2","R4","R4","R3","R3","R9","R3","R2","R6","R6","R9","R8",
                        "R7","R6","R7","R4","R8","R5","R5","R5","R2","R9","R9","R7"};

    task automatic check_out(string tag, logic [3:0] exp);
        logic [3:0] act;
        act = {role_master, role_xmit, slave_hit, data_strobe};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {master,xmit,hit,strobe} actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive_idle();
        {sw_mst_we, sw_mst_val, sw_trx_we, sw_trx_val} = 4'b0;
        {bus_start, bus_stop, arb_lost, rx_done} = 4'b0;
        rx_byte = 8'h00;
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check_out("R1", 4'b0000); // reset state R1
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {cfg_free_data, bus_start, bus_stop, arb_lost, sw_mst_we, sw_mst_val,
             sw_trx_we, sw_trx_val, rx_done} = VEC[i][20:12];
            rx_byte = VEC[i][11:4];
            @(posedge clk);
            #2;
            check_out(TAG[i], VEC[i][3:0]);
        end
        // R1: reset in the middle of an addressed transfer
        @(negedge clk);
        drive_idle();
        sw_mst_we = 1'b1; sw_mst_val = 1'b1; sw_trx_we = 1'b1; sw_trx_val = 1'b1;
        @(posedge clk); #2;
        check_out("R6", 4'b1100);
        @(negedge clk);
        drive_idle();
        rst = 1'b1;
        @(posedge clk); #2;
        check_out("R1", 4'b0000);
        @(negedge clk);
        rst = 1'b0;
        // R4: first byte after start while reset-fresh
        bus_start = 1'b1;
        @(posedge clk); #2;
        @(negedge clk);
        drive_idle();
        rx_done = 1'b1; rx_byte = 8'hB5;
        @(posedge clk); #2;
        check_out("R2", 4'b0110);
        @(negedge clk);
        drive_idle();
        @(posedge clk); #2;
        check_out("R4", 4'b0110);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule